// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block holds received data for one non-control OUT endpoint of a USB device controller. The packet engine writes bytes in as they arrive and pulses an end strobe when a packet has passed its checks. The block then presents the packet to the CPU: it raises a packet-ready flag, exposes the 11-bit byte count and lets the CPU unload the bytes one at a time through a data port.

One control byte carries three settings and two flags. The settings are auto-clear, endpoint type (bulk/interrupt or isochronous) and double buffering. The flags are packet-ready and overrun. Each flag is cleared by writing 1 to it. With double buffering on, a second packet can arrive while the first is still being read.

A slot-tracking state machine decides when packet-ready rises and falls. Its states are SL_EMPTY, SL_HOLD1, SL_HOLD2 and SL_ADVANCE. The transitions are:

- SL_EMPTY to SL_HOLD1 on a commit.
- SL_HOLD1 to SL_HOLD2 on a commit.
- SL_HOLD1 to SL_EMPTY on a release.
- SL_HOLD1 to SL_ADVANCE on a release and a commit in the same cycle.
- SL_HOLD2 to SL_ADVANCE on a release.
- SL_ADVANCE to SL_HOLD1, or to SL_HOLD2 if a commit lands.

SL_ADVANCE is the one-cycle gap before a waiting packet is presented. Packet-ready is high in SL_HOLD1 and SL_HOLD2.

Top module: `usb_out_rxbuf`

## Requirements
- R1: After reset, the control byte reads 0x00. Both count bytes read 0x00, rd_data is 0x00 and rx_full is low.
- R2: Control byte layout: bit 7 auto-clear, bit 6 isochronous, bit 5 double buffering, bit 1 overrun, bit 0 packet-ready. Bits 7:5 are written directly. Bits 4:2 read as zero and writes to them are ignored. Bits 1 and 0 are cleared only by writing 1.
- R3: One cycle after a good packet ends, packet-ready is 1. The count equals the number of bytes stored: cnt_lo carries bits 7:0, cnt_hi bits 2:0 carry bits 10:8, and cnt_hi bits 7:3 read zero.
- R4: While packet-ready is 0, both count bytes read zero.
- R5: A read strobe while packet-ready is set loads the next byte of the packet, in arrival order, onto rd_data one cycle later. A strobe while not ready, or past the packet's last byte, loads zero and does not move the read position.
- R6: Writing 1 to bit 0 while packet-ready is set clears it and frees the slot. Writing 1 while it is clear has no effect.
- R7: With auto-clear on and a packet length equal to the nonzero max_pkt value, the read of the last byte clears packet-ready at the same clock edge that delivers that byte.
- R8: With auto-clear off, or with a packet shorter than max_pkt, reading every byte leaves packet-ready set.
- R9: In single-buffer mode, rx_full is high while one packet is held. Bytes and end strobes arriving while full are ignored, and the held packet's count and data stay unchanged.
- R10: In double-buffer mode, two packets are held and rx_full rises only when both are held. When the first is released with a second waiting, packet-ready is low for exactly one cycle and then high, with the second packet's count and data.
- R11: In isochronous mode, an end strobe arriving while full sets the overrun bit. In bulk mode it does not. Writing 1 to bit 1 clears the overrun bit.
- R12: Bytes beyond the slot capacity SLOT_BYTES are discarded and not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Packet engine delivers one data byte |
| rx_data | input | DATA_W | Received data byte |
| rx_end | input | 1 | Good end of the packet being received |
| rx_full | output | 1 | Every enabled slot holds an unread packet |
| csr_wr | input | 1 | Control byte write strobe |
| csr_wdata | input | 8 | Control byte write data |
| csr_rdata | output | 8 | Control byte read value |
| max_pkt | input | 11 | Programmed maximum packet size |
| cnt_lo | output | 8 | Byte count bits 7:0 |
| cnt_hi | output | 8 | Byte count bits 10:8 in bits 2:0, upper bits zero |
| rd_en | input | 1 | Data port read strobe; removes one byte |
| rd_data | output | DATA_W | Byte returned by the previous read strobe |

## Verification
The bench builds the block with SLOT_BYTES = 16 and DATA_W = 8. The small slot lets a 20-byte packet reach the truncation path of R12 within a few cycles. max_pkt is set to 8, so full-size packets for auto-clear stay short. Switching the control byte between single buffering, double buffering and isochronous mode drives every state and transition of the slot machine, including the one-cycle SL_ADVANCE gap and the overrun path.

// File: rtl/usb_rxbuf_pkg.sv
package usb_rxbuf_pkg;

    // Width of the received byte count (up to 1023 + spare bit)
    localparam int CNT_W = 11;

    // Control byte bit positions
    localparam int CB_RDY  = 0;
    localparam int CB_OVR  = 1;
    localparam int CB_DBL  = 5;
    localparam int CB_ISO  = 6;
    localparam int CB_AUTO = 7;

    // Slot-tracking states
    typedef enum logic [1:0] {
        SL_EMPTY   = 2'd0,
        SL_HOLD1   = 2'd1,
        SL_HOLD2   = 2'd2,
        SL_ADVANCE = 2'd3
    } slot_state_e;

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
    parameter int DATA_W     = 8,
    parameter int SLOT_BYTES = 64,
    localparam int IW        = $clog2(SLOT_BYTES),
    localparam int AW        = IW + 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 2 * SLOT_BYTES;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rxbuf_fill.sv
module rxbuf_fill
    import usb_rxbuf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SLOT_BYTES = 64,
    localparam int IW        = $clog2(SLOT_BYTES),
    localparam int AW        = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_end,
    input  logic              full,
    input  logic              iso,
    input  logic              dbl,
    input  logic              rd_slot,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic              ovr_set,
    output logic [CNT_W-1:0]  rd_len
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(SLOT_BYTES);

    logic               wslot_q;
    logic [CNT_W-1:0]   wcnt_q;
    logic               take;
    logic [CNT_W-1:0]   wcnt_nx;
    logic [2*CNT_W-1:0] len_flat;

    assign take    = rx_valid && !full && (wcnt_q < CAP);
    assign commit  = rx_end && !full;
    assign ovr_set = rx_end && full && iso;
    assign wcnt_nx = wcnt_q + CNT_W'(take);

    assign we    = take;
    assign waddr = {wslot_q, wcnt_q[IW-1:0]};
    assign wdata = rx_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wslot_q <= 1'b0;
            wcnt_q  <= '0;
        end else if (commit) begin
            wcnt_q  <= '0;
            wslot_q <= dbl ? ~wslot_q : wslot_q;
        end else begin
            wcnt_q  <= wcnt_nx;
        end
    end

    // One length register per slot
    for (genvar g = 0; g < 2; g++) begin : g_len
        logic [CNT_W-1:0] len_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q <= '0;
            end else if (commit && (wslot_q == g[0])) begin
                len_q <= wcnt_nx;
            end
        end
        assign len_flat[g*CNT_W +: CNT_W] = len_q;
    end

    assign rd_len = rd_slot ? len_flat[CNT_W +: CNT_W] : len_flat[0 +: CNT_W];

    // R12: the fill count never passes the slot capacity
    p_len_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= CAP);

endmodule

// File: rtl/rxbuf_slot_fsm.sv
module rxbuf_slot_fsm
    import usb_rxbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic release_slot,
    input  logic dbl,
    output logic pkt_rdy,
    output logic full
);

    slot_state_e state_q, state_nx;
    logic [1:0]  held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_EMPTY;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SL_EMPTY: begin
                if (commit) state_nx = SL_HOLD1;
            end
            SL_HOLD1: begin
                if (release_slot && commit) state_nx = SL_ADVANCE;
                else if (release_slot)      state_nx = SL_EMPTY;
                else if (commit)            state_nx = SL_HOLD2;
            end
            SL_HOLD2: begin
                if (release_slot) state_nx = SL_ADVANCE;
            end
            SL_ADVANCE: begin
                state_nx = commit ? SL_HOLD2 : SL_HOLD1;
            end
        endcase
    end

    always_comb begin
        pkt_rdy = 1'b0;
        held    = 2'd0;
        unique case (state_q)
            SL_EMPTY:   begin pkt_rdy = 1'b0; held = 2'd0; end
            SL_HOLD1:   begin pkt_rdy = 1'b1; held = 2'd1; end
            SL_HOLD2:   begin pkt_rdy = 1'b1; held = 2'd2; end
            SL_ADVANCE: begin pkt_rdy = 1'b0; held = 2'd1; end
        endcase
        full = dbl ? (held == 2'd2) : (held != 2'd0);
    end

    // R3: a packet committed into an empty buffer is presented next cycle
    p_rdy_after_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_EMPTY && commit) |=> pkt_rdy);

    // R10: releasing with a packet waiting gives a one-cycle gap
    p_adv_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_HOLD2 && release_slot) |=> (!pkt_rdy ##1 pkt_rdy));

endmodule

// File: rtl/usb_out_rxbuf.sv
module usb_out_rxbuf
    import usb_rxbuf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SLOT_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_end,
    output logic              rx_full,
    input  logic              csr_wr,
    input  logic [7:0]        csr_wdata,
    output logic [7:0]        csr_rdata,
    input  logic [CNT_W-1:0]  max_pkt,
    output logic [7:0]        cnt_lo,
    output logic [7:0]        cnt_hi,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IW = $clog2(SLOT_BYTES);
    localparam int AW = IW + 1;

    // Control settings and flags
    logic auto_q, iso_q, dbl_q, ovr_q;

    // Reader state
    logic              rslot_q;
    logic [CNT_W-1:0]  rptr_q;

    // Interconnect
    logic              pkt_rdy, full;
    logic              commit, ovr_set, release_slot;
    logic              we;
    logic [AW-1:0]     waddr;
    logic [DATA_W-1:0] wdata, sdata;
    logic [CNT_W-1:0]  cur_len, cnt;
    logic              rd_ok, auto_evt, cpu_rel;
    logic              unused_bits;

    assign unused_bits = ^csr_wdata[4:2];

    rxbuf_store #(.DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr ({rslot_q, rptr_q[IW-1:0]}),
        .rdata (sdata)
    );

    rxbuf_fill #(.DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_end   (rx_end),
        .full     (full),
        .iso      (iso_q),
        .dbl      (dbl_q),
        .rd_slot  (rslot_q),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .commit   (commit),
        .ovr_set  (ovr_set),
        .rd_len   (cur_len)
    );

    rxbuf_slot_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .release_slot (release_slot),
        .dbl          (dbl_q),
        .pkt_rdy      (pkt_rdy),
        .full         (full)
    );

    // Read and release decisions
    assign rd_ok        = rd_en && pkt_rdy && (rptr_q < cur_len);
    assign auto_evt     = auto_q && rd_ok && (cur_len == max_pkt) && (cur_len != '0)
                          && (rptr_q == cur_len - CNT_W'(1));
    assign cpu_rel      = csr_wr && csr_wdata[CB_RDY];
    assign release_slot = pkt_rdy && (cpu_rel || auto_evt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rptr_q  <= '0;
            rslot_q <= 1'b0;
        end else begin
            if (rd_en) begin
                rd_data <= rd_ok ? sdata : '0;
            end
            if (release_slot) begin
                rptr_q  <= '0;
                rslot_q <= dbl_q ? ~rslot_q : rslot_q;
            end else if (rd_ok) begin
                rptr_q  <= rptr_q + CNT_W'(1);
            end
        end
    end

    // Control byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            iso_q  <= 1'b0;
            dbl_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (csr_wr) begin
                auto_q <= csr_wdata[CB_AUTO];
                iso_q  <= csr_wdata[CB_ISO];
                dbl_q  <= csr_wdata[CB_DBL];
            end
            if (ovr_set) begin
                ovr_q <= 1'b1;
            end else if (csr_wr && csr_wdata[CB_OVR]) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign csr_rdata = {auto_q, iso_q, dbl_q, 3'b000, ovr_q, pkt_rdy};
    assign rx_full   = full;

    // Count readout
    assign cnt    = pkt_rdy ? cur_len : '0;
    assign cnt_lo = cnt[7:0];
    assign cnt_hi = {5'b00000, cnt[CNT_W-1:8]};

    // R5: idle reads return zero and leave the read position alone
    p_rd_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !pkt_rdy) |=> (rd_data == '0 && $stable(rptr_q)));

    // R7: auto-clear drops packet-ready at the edge of the last read
    p_auto_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        auto_evt |=> !pkt_rdy);

    // R11: overrun only rises in isochronous mode
    p_ovr_iso_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(iso_q));

endmodule

// File: tb/sim_usb_out_rxbuf.sv
module sim_usb_out_rxbuf;

    localparam int SLOT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_end = 1'b0;
    logic        rx_full;
    logic        csr_wr = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic [10:0] max_pkt = 11'd8;
    logic [7:0]  cnt_lo, cnt_hi;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;

    always #5 clk = ~clk;

    usb_out_rxbuf #(.DATA_W(8), .SLOT_BYTES(SLOT)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_full(rx_full), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .max_pkt(max_pkt),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .rd_en(rd_en), .rd_data(rd_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [7:0] q_dat[$];
    int         q_len[$];
    logic [7:0] wb[$];
    bit         m_auto, m_iso, m_dbl, m_ovr, m_rdy, m_adv;
    int         m_rptr;
    logic [7:0] m_rd;
    int         slots, hl;
    bit         mfull, rok, aev, rel, oset;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_dat.delete(); q_len.delete(); wb.delete();
            m_auto = 0; m_iso = 0; m_dbl = 0; m_ovr = 0; m_rdy = 0; m_adv = 0;
            m_rptr = 0; m_rd = '0;
        end else begin
            slots = m_dbl ? 2 : 1;
            mfull = (q_len.size() >= slots);
            hl    = m_rdy ? q_len[0] : 0;
            rok   = rd_en && m_rdy && (m_rptr < hl);
            aev   = rok && m_auto && (hl == int'(max_pkt)) && (hl != 0) && (m_rptr == hl - 1);
            rel   = m_rdy && ((csr_wr && csr_wdata[0]) || aev);
            oset  = 0;
            if (rd_en) m_rd = rok ? q_dat[m_rptr] : 8'h00;
            if (rok) m_rptr++;
            if (!mfull) begin
                if (rx_valid && wb.size() < SLOT) wb.push_back(rx_data);
                if (rx_end) begin
                    q_len.push_back(wb.size());
                    foreach (wb[i]) q_dat.push_back(wb[i]);
                    wb.delete();
                end
            end else if (rx_end && m_iso) begin
                oset = 1;
            end
            if (oset) m_ovr = 1;
            else if (csr_wr && csr_wdata[1]) m_ovr = 0;
            if (csr_wr) begin
                m_auto = csr_wdata[7]; m_iso = csr_wdata[6]; m_dbl = csr_wdata[5];
            end
            if (rel) begin
                for (int i = 0; i < hl; i++) void'(q_dat.pop_front());
                void'(q_len.pop_front());
                m_rptr = 0; m_rdy = 0; m_adv = (q_len.size() > 0);
            end else if (m_adv) begin
                m_adv = 0; m_rdy = 1;
            end else if (!m_rdy && q_len.size() > 0) begin
                m_rdy = 1;
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 control byte", csr_rdata,
                {m_auto, m_iso, m_dbl, 3'b000, m_ovr, m_rdy});
            chk("R3 count", {cnt_hi, cnt_lo}, m_rdy ? q_len[0] : 0);
            chk("R9 full", rx_full, (q_len.size() >= (m_dbl ? 2 : 1)) ? 1 : 0);
            chk("R5 read data", rd_data, m_rd);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_pkt(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_data = base + 8'(i);
            tick();
        end
        rx_valid = 1'b0; rx_end = 1'b1;
        tick();
        rx_end = 1'b0;
    endtask

    task automatic rd1();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic wcsr(input logic [7:0] v);
        csr_wr = 1'b1; csr_wdata = v;
        tick();
        csr_wr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 ctrl", csr_rdata, 8'h00);
        chk("R1 count", {cnt_hi, cnt_lo}, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 full", rx_full, 0);

        // R2 writable bits and reserved bits
        wcsr(8'hFF);
        chk("R2 reserved zero", csr_rdata, 8'hE0);
        wcsr(8'h00);

        // Bulk single packet
        send_pkt(5, 8'h10);
        chk("R3 ready", csr_rdata[0], 1);
        chk("R3 cnt_lo", cnt_lo, 5);
        chk("R3 cnt_hi", cnt_hi, 0);
        chk("R9 full single", rx_full, 1);
        rd1();
        chk("R5 first byte", rd_data, 8'h10);
        for (int i = 1; i < 5; i++) rd1();
        chk("R5 last byte", rd_data, 8'h14);
        rd1();
        chk("R5 past end", rd_data, 0);
        chk("R8 no auto-clear", csr_rdata[0], 1);
        send_pkt(3, 8'hA0);
        chk("R9 ignored count", cnt_lo, 5);
        chk("R11 bulk no overrun", csr_rdata, 8'h01);
        wcsr(8'h01);
        chk("R6 release", csr_rdata[0], 0);
        chk("R4 count idle", {cnt_hi, cnt_lo}, 0);
        wcsr(8'h01);
        chk("R6 no-op release", csr_rdata, 8'h00);
        rd1();
        chk("R5 idle read", rd_data, 0);

        // R12 truncation
        send_pkt(20, 8'h30);
        chk("R12 capped count", cnt_lo, SLOT);
        wcsr(8'h01);

        // R7 / R8 auto-clear
        wcsr(8'h80);
        send_pkt(8, 8'h50);
        for (int i = 0; i < 7; i++) rd1();
        chk("R7 still ready", csr_rdata[0], 1);
        rd1();
        chk("R7 auto-cleared", csr_rdata[0], 0);
        chk("R7 last byte", rd_data, 8'h57);
        send_pkt(4, 8'h60);
        for (int i = 0; i < 4; i++) rd1();
        chk("R8 short stays", csr_rdata[0], 1);
        wcsr(8'h81);
        wcsr(8'h00);

        // R10 double buffering
        wcsr(8'h20);
        send_pkt(3, 8'h70);
        chk("R10 one held not full", rx_full, 0);
        send_pkt(6, 8'h80);
        chk("R10 two held full", rx_full, 1);
        chk("R10 first count", cnt_lo, 3);
        wcsr(8'h21);
        chk("R10 gap low", csr_rdata[0], 0);
        tick();
        chk("R10 second ready", csr_rdata[0], 1);
        chk("R10 second count", cnt_lo, 6);
        rd1();
        chk("R10 second data", rd_data, 8'h80);
        wcsr(8'h21);
        wcsr(8'h00);

        // R11 isochronous overrun
        wcsr(8'h40);
        send_pkt(2, 8'h90);
        send_pkt(3, 8'hB0);
        chk("R11 overrun set", csr_rdata, 8'h43);
        chk("R11 held count", cnt_lo, 2);
        wcsr(8'h42);
        chk("R11 overrun clear", csr_rdata, 8'h41);
        wcsr(8'h41);
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule